// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single channel of a memory-to-memory DMA engine. A peripheral raises a request. The channel then produces one beat per clock on a simple memory port. Each beat carries a read address, a write address and a byte count. The data path itself sits outside the block: the word read in a beat is written in the same beat.

The source side and the destination side each have their own address policy: fixed, increment or decrement. Each side also has its own step size. One configuration word sets the buffer length and the trigger mode. The trigger mode decides how much data one request moves: a single buffer, a whole block, or a block repeated a programmed number of times. The descriptor-chained mode runs the same repeated block with the fixed descriptor held on the inputs.

When no hardware acknowledge exists, the channel can finish a unit by writing a programmed value to a programmed address. It reports progress with a busy flag and a one-cycle done pulse. It also presents a request flag and a 2-bit priority for an external arbiter. Configuration inputs must stay stable while the channel is busy.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is idle: busy, done, rd_en, wr_en, ack_wr and arb_req are all 0.
- R2: The source address mode is cfg[1:0]. Values 00 and 01 keep rd_addr fixed. Value 10 adds the source step after each beat, and 11 subtracts it. A new block starts rd_addr at src_base.
- R3: The destination address mode is cfg[3:2], with the same encoding as R2. It applies to wr_addr with the destination step, and a new block starts wr_addr at dst_base.
- R4: The source step is 1, 2, 4 or 8 bytes for cfg[9:8] = 00, 01, 10 or 11. The destination step comes from cfg[11:10] with the same encoding. Each beat carries rd_bytes = wr_bytes = the minimum of the source step, the bytes left in the buffer and the bytes left in the block.
- R5: The buffer length is cfg[25:18], valid from 1 to 128 bytes. A block of blk_len bytes (nonzero) is split into buffers of that length, and the last buffer may be shorter.
- R6: With trigger mode cfg[29:28] = 00, one request moves one buffer. The next request continues at the following addresses. A request after a block is exhausted starts a new block from the base addresses.
- R7: With trigger mode 01, one request moves the whole block with no gap between beats.
- R8: With trigger mode 10 or 11, one request moves the block rep_cnt+1 times. Each repetition restarts from the base addresses.
- R9: When ack_en is 1, the cycle after the last beat of a unit is an acknowledge write. In that cycle wr_en=1, rd_en=0, wr_addr=ack_addr, wr_data=ack_val, wr_bytes=4 and ack_wr=1.
- R10: The first beat appears the cycle after the request is sampled, and busy stays high until the unit ends. done is a one-cycle pulse in the first idle cycle.
- R11: A request that arrives while the channel is busy is held. It is served right after done, with no further request.
- R12: arb_req is high while the channel is busy or holds a pending request, and arb_prio always equals prio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request pulse |
| cfg | input | 32 | Channel configuration word |
| prio | input | 2 | Channel priority level |
| src_base | input | AW | Source block start address |
| dst_base | input | AW | Destination block start address |
| blk_len | input | LW | Block length in bytes |
| rep_cnt | input | RW | Extra repetitions in repeated modes |
| ack_en | input | 1 | Enable software acknowledge write |
| ack_addr | input | AW | Acknowledge write address |
| ack_val | input | 32 | Acknowledge write value |
| rd_en | output | 1 | Read beat valid |
| rd_addr | output | AW | Read address |
| rd_bytes | output | 4 | Read beat byte count |
| wr_en | output | 1 | Write beat valid |
| wr_addr | output | AW | Write address |
| wr_bytes | output | 4 | Write beat byte count |
| wr_data | output | 32 | Acknowledge value during an acknowledge write, else 0 |
| ack_wr | output | 1 | Marks the acknowledge write |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle end-of-unit pulse |
| arb_req | output | 1 | Request flag for an arbiter |
| arb_prio | output | 2 | Priority for an arbiter |

## Verification
The bench sweeps all 256 combinations of the two address modes and the two step sizes in block mode, using a 13-byte block cut into 5-byte buffers. This separates wrong step sizes, swapped sides, a mishandled reserved mode and a failure to clip the beat at buffer and block edges. Buffer mode runs over several requests, with the block length not a multiple of the buffer length. These runs show whether addresses carry across requests and whether they restart at the block edge. Repeated and chained modes, buffer lengths of 1 and 128, acknowledge on and off, and a request raised mid-transfer separate errors in repetition count, in acknowledge placement and in pending-request handling.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int LW = 17,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [31:0]   cfg,
  input  logic [1:0]    prio,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [LW-1:0] blk_len,
  input  logic [RW-1:0] rep_cnt,
  input  logic          ack_en,
  input  logic [AW-1:0] ack_addr,
  input  logic [31:0]   ack_val,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [3:0]    rd_bytes,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [3:0]    wr_bytes,
  output logic [31:0]   wr_data,
  output logic          ack_wr,
  output logic          busy,
  output logic          done,
  output logic          arb_req,
  output logic [1:0]    arb_prio
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_ACK} st_t;
  st_t st;
  logic [AW-1:0] src, dst;
  logic [LW-1:0] blk_rem;
  logic [7:0]    buf_rem;
  logic [RW-1:0] rep_left;
  logic          pend, done_q;

  wire [1:0] smode = cfg[1:0];
  wire [1:0] dmode = cfg[3:2];
  wire [3:0] sstep = 4'd1 << cfg[9:8];
  wire [3:0] dstep = 4'd1 << cfg[11:10];
  wire [7:0] buf_len = cfg[25:18];
  wire [1:0] tmode = cfg[29:28];

  logic [3:0] beat;
  always_comb begin
    beat = sstep;
    if (buf_rem < {4'd0, beat}) beat = buf_rem[3:0];
    if (blk_rem < LW'(beat)) beat = blk_rem[3:0];
  end

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic [1:0] m,
                                              input logic [3:0] s);
    if (m == 2'b10) return a + AW'(s);
    if (m == 2'b11) return a - AW'(s);
    return a;
  endfunction

  wire in_xfer  = (st == S_XFER);
  wire in_ack   = (st == S_ACK);
  wire start    = (st == S_IDLE) && (req || pend);
  wire blk_end  = (blk_rem == LW'(beat));
  wire buf_end  = (buf_rem == {4'd0, beat});
  wire again    = tmode[1] && (rep_left != '0);
  wire unit_end = in_xfer && ((blk_end && !again) || (!blk_end && buf_end && tmode == 2'b00));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; src <= '0; dst <= '0; blk_rem <= '0; buf_rem <= '0;
      rep_left <= '0; pend <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pend   <= (pend || req) && !start;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_XFER;
          buf_rem <= buf_len;
          if (blk_rem == '0) begin
            src <= src_base; dst <= dst_base; blk_rem <= blk_len; rep_left <= rep_cnt;
          end
        end
        S_XFER: begin
          src     <= step_addr(src, smode, sstep);
          dst     <= step_addr(dst, dmode, dstep);
          blk_rem <= blk_rem - LW'(beat);
          buf_rem <= buf_rem - {4'd0, beat};
          if (blk_end && again) begin
            rep_left <= rep_left - 1'b1;
            src <= src_base; dst <= dst_base; blk_rem <= blk_len; buf_rem <= buf_len;
          end else if (!blk_end && buf_end && tmode != 2'b00) begin
            buf_rem <= buf_len;
          end
          if (unit_end) begin
            if (ack_en) st <= S_ACK;
            else begin st <= S_IDLE; done_q <= 1'b1; end
          end
        end
        default: begin st <= S_IDLE; done_q <= 1'b1; end
      endcase
    end
  end

  assign rd_en    = in_xfer;
  assign rd_addr  = src;
  assign rd_bytes = in_xfer ? beat : 4'd0;
  assign wr_en    = in_xfer || in_ack;
  assign wr_addr  = in_ack ? ack_addr : dst;
  assign wr_bytes = in_ack ? 4'd4 : (in_xfer ? beat : 4'd0);
  assign wr_data  = in_ack ? ack_val : 32'd0;
  assign ack_wr   = in_ack;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign arb_req  = busy || pend;
  assign arb_prio = prio;

  a_r2_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && !smode[1] && $stable(cfg) && $stable(src_base)) |-> $stable(rd_addr));
  a_r4_beat_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_bytes != 4'd0 && rd_bytes <= sstep && wr_bytes == rd_bytes));
  a_r9_ack_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |-> ($past(rd_en) && wr_en && !rd_en && wr_addr == ack_addr));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> arb_req);
endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [31:0] cfg = '0, sbase = 32'h0000_1000, dbase = 32'h0000_8000;
  logic [1:0]  prio = 2'b10;
  logic [16:0] blen = 17'd13;
  logic [3:0]  reps = '0;
  logic        ack_en = 1'b0;
  logic [31:0] ack_addr = 32'h4000_0040, ack_val = 32'hA5C3_0001;
  logic        rd_en, wr_en, ack_wr, busy, done, arb_req;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [3:0]  rd_bytes, wr_bytes;
  logic [1:0]  arb_prio;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_src, m_dst;
  int m_blk = 0, m_buf = 0, m_rep = 0;

  always #10 clk = ~clk;

  dma_chan_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg(cfg), .prio(prio),
    .src_base(sbase), .dst_base(dbase), .blk_len(blen), .rep_cnt(reps),
    .ack_en(ack_en), .ack_addr(ack_addr), .ack_val(ack_val),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bytes(wr_bytes), .wr_data(wr_data),
    .ack_wr(ack_wr), .busy(busy), .done(done), .arb_req(arb_req), .arb_prio(arb_prio));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] adv(input logic [31:0] a, input logic [1:0] m, input logic [1:0] sz);
    if (m == 2'b10) return a + (32'd1 << sz);
    if (m == 2'b11) return a - (32'd1 << sz);
    return a;
  endfunction

  function automatic logic [31:0] mk(input int sm, input int dm, input int ss, input int ds,
                                     input int bl, input int tm);
    return (32'(tm) << 28) | (32'(bl) << 18) | (32'(ds) << 10) | (32'(ss) << 8)
         | (32'(dm) << 2) | 32'(sm);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; m_blk = 0;
    @(negedge clk);
  endtask

  task automatic serve(input string tag, input bit pulse, input bit raise_pend);
    bit fin = 0;
    bit first = 1;
    int beat;
    if (pulse) begin req = 1'b1; @(negedge clk); req = 1'b0; end
    if (m_blk == 0) begin m_src = sbase; m_dst = dbase; m_blk = int'(blen); m_rep = int'(reps); end
    m_buf = int'(cfg[25:18]);
    while (!fin) begin
      beat = 1 << cfg[9:8];
      if (m_buf < beat) beat = m_buf;
      if (m_blk < beat) beat = m_blk;
      chk(tag, {rd_en, wr_en, rd_addr, wr_addr, rd_bytes, wr_bytes, arb_req, arb_prio, busy},
          {2'b11, m_src, m_dst, 4'(beat), 4'(beat), 1'b1, prio, 1'b1});
      if (raise_pend && first) req = 1'b1;
      first = 0;
      m_src = adv(m_src, cfg[1:0], cfg[9:8]);
      m_dst = adv(m_dst, cfg[3:2], cfg[11:10]);
      m_buf -= beat; m_blk -= beat;
      if (m_blk == 0) begin
        if (cfg[29] && m_rep != 0) begin
          m_rep--; m_src = sbase; m_dst = dbase; m_blk = int'(blen); m_buf = int'(cfg[25:18]);
        end else fin = 1;
      end else if (m_buf == 0) begin
        if (cfg[29:28] == 2'b00) fin = 1;
        else m_buf = int'(cfg[25:18]);
      end
      @(negedge clk);
      req = 1'b0;
    end
    if (ack_en) begin
      chk({tag, " R9 ack"}, {rd_en, wr_en, wr_addr, wr_bytes, wr_data, ack_wr},
          {1'b0, 1'b1, ack_addr, 4'd4, ack_val, 1'b1});
      @(negedge clk);
    end
    chk({tag, " R10 done"}, {done, busy, rd_en, ack_wr}, 4'b1000);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset", {busy, done, rd_en, wr_en, ack_wr, arb_req}, 6'b0);

    // R2 R3 R4 R7: every address mode and step pairing, block mode
    blen = 17'd13;
    for (int sm = 0; sm < 4; sm++)
      for (int dm = 0; dm < 4; dm++)
        for (int ss = 0; ss < 4; ss++)
          for (int ds = 0; ds < 4; ds++) begin
            cfg = mk(sm, dm, ss, ds, 5, 1);
            ack_en = ((sm + ds) % 2) == 1;
            serve("R2 R3 R4 R7 sweep", 1, 0);
          end

    // R5 R6: buffer mode across requests and the block edge
    do_reset(); ack_en = 1'b0; blen = 17'd20;
    cfg = mk(2, 3, 1, 2, 6, 0);
    for (int k = 0; k < 6; k++) serve("R5 R6 buffer", 1, 0);
    do_reset(); blen = 17'd3; cfg = mk(2, 2, 3, 0, 1, 0);
    for (int k = 0; k < 4; k++) serve("R5 R6 buffer len 1", 1, 0);
    do_reset(); blen = 17'd130; cfg = mk(2, 2, 3, 3, 128, 0);
    for (int k = 0; k < 3; k++) serve("R5 R6 buffer len 128", 1, 0);

    // R8: repeated and chained modes
    do_reset(); blen = 17'd7; reps = 4'd2; cfg = mk(2, 3, 1, 0, 3, 2);
    serve("R8 repeat", 1, 0);
    ack_en = 1'b1; reps = 4'd1; cfg = mk(3, 2, 0, 1, 4, 3);
    serve("R8 chained", 1, 0);
    reps = 4'd0; cfg = mk(2, 2, 2, 2, 8, 2);
    serve("R8 single pass", 1, 0);

    // R11 R12: request held while busy
    ack_en = 1'b0; prio = 2'b01; blen = 17'd9; cfg = mk(2, 2, 0, 0, 4, 1);
    serve("R11 R12 first", 1, 1);
    serve("R11 pending served", 0, 0);
    chk("R11 R12 idle after", {busy, arb_req, rd_en}, 3'b000);
    ack_en = 1'b1; prio = 2'b11;
    serve("R11 R12 first ack", 1, 1);
    serve("R11 pending ack", 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule